// File: doc/BRIEF.md
# Serial DAC Word Loader

This block turns one parallel sample word into the three-wire serial transfer that a serial-input multiplying DAC expects. A producer offers a word on a valid/ready input. Once the block accepts the word, it shifts the word out one bit per shift-clock pulse, most significant bit first. It then lowers a load strobe for a single state clock so that the DAC latches the complete word.

The state machine advances on a slow state clock, nominally 1 MHz. Each half of a shift-clock period lasts a whole number of state clocks, and the parameter `HALF_CYC` sets that number. The input follows valid/ready rules, and the only back-pressure is the transfer in flight. `in_ready` is high exactly when the block is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. While a transfer runs, the producer may hold `in_valid` high and change `in_data`, and neither has any effect. `busy` and `done` are plain status pins.

Top module: `serial_dac_loader`

## Requirements
- R1: A word is accepted only on a rising clock edge with `in_valid` and `in_ready` both high. `in_ready` is low for the whole transfer and high again in the cycle where `done` is high.
- R2: Every accepted word produces exactly `WORD_W` (16) rising edges of `sck` before `load_n` goes low.
- R3: Bits leave on `sdo` most significant bit first. The bit for a pulse is present before that pulse's `sck` rising edge, and `sdo` changes only in cycles where `sck` is low.
- R4: `load_n` is high at idle. It goes low for exactly one state clock, in cycle 32·HALF_CYC+1 after the accepting edge, which is after the sixteenth `sck` rise and with `sck` low.
- R5: `done` is high for exactly one cycle, at cycle 32·HALF_CYC+2 after the accepting edge, directly after the `load_n` low cycle.
- R6: Changes on `in_data` and a held `in_valid` during a transfer are ignored. The word that is shifted is the word captured at acceptance, and no extra transfer starts.
- R7: `sck` is low whenever the block is idle. Rise k (k = 0..15) comes at cycle (2k+1)·HALF_CYC after the accepting edge, and each high and each low phase lasts HALF_CYC cycles.
- R8: After reset, `sck`=0, `load_n`=1, `sdo`=0, `busy`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block can accept a word (idle) |
| in_data | input | WORD_W | Parallel word to transmit |
| sck | output | 1 | Shift clock to the DAC, idles low |
| sdo | output | 1 | Serial data to the DAC |
| load_n | output | 1 | Active-low latch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
Every result is measured in state-clock cycles from the accepting edge. Shift rise k is due at (2k+1)·HALF_CYC, the load strobe at 32·HALF_CYC+1, and the done pulse one cycle after that. The monitor counts edges and samples on the falling clock edge, midway between active edges. It stamps each handshake with the edge number on which the word is taken and compares every event against these offsets. The scoreboard rebuilds the shifted word from `sdo` at each observed `sck` rise. It compares that word with the word the driver queued when the handshake was seen.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LO    = 3'd1,
    ST_HI    = 3'd2,
    ST_TAIL  = 3'd3,
    ST_LATCH = 3'd4
  } sdac_state_e;

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || expire) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int WORD_W    = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  output logic              sdo,
  output logic              last_bit
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] shifted;
  logic [CNT_W-1:0]  bit_cnt_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sdo     = shreg_q[WORD_W-1];
      assign shifted = {shreg_q[WORD_W-2:0], 1'b0};
    end else begin : g_lsb
      assign sdo     = shreg_q[0];
      assign shifted = {1'b0, shreg_q[WORD_W-1:1]};
    end
  endgenerate

  assign last_bit = (bit_cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
    end else if (load_en) begin
      shreg_q   <= load_word;
      bit_cnt_q <= '0;
    end else if (advance) begin
      shreg_q   <= shifted;
      bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdac_sequencer.sv
module sdac_sequencer
  import sdac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic expire,
  input  logic last_bit,
  output logic capture,
  output logic advance,
  output logic sck,
  output logic load_n,
  output logic done,
  output logic busy
);
  sdac_state_e state_q, state_d;
  logic sck_q, load_n_q, done_q;

  assign capture = (state_q == ST_IDLE) && in_valid;
  assign advance = (state_q == ST_HI) && expire && !last_bit;
  assign busy    = (state_q != ST_IDLE);
  assign sck     = sck_q;
  assign load_n  = load_n_q;
  assign done    = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (in_valid) state_d = ST_LO;
      ST_LO:    if (expire)   state_d = ST_HI;
      ST_HI:    if (expire)   state_d = last_bit ? ST_TAIL : ST_LO;
      ST_TAIL:  state_d = ST_LATCH;
      ST_LATCH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sck_q    <= 1'b0;
      load_n_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      sck_q    <= (state_d == ST_HI);
      load_n_q <= (state_d != ST_LATCH);
      done_q   <= (state_q == ST_LATCH);
    end
  end
endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader #(
  parameter int WORD_W    = 16,
  parameter int HALF_CYC  = 1,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sck,
  output logic              sdo,
  output logic              load_n,
  output logic              busy,
  output logic              done
);
  logic capture, advance, expire, last_bit;

  sdac_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (capture),
    .expire  (expire)
  );

  sdac_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (capture),
    .load_word (in_data),
    .advance   (advance),
    .sdo       (sdo),
    .last_bit  (last_bit)
  );

  sdac_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .expire   (expire),
    .last_bit (last_bit),
    .capture  (capture),
    .advance  (advance),
    .sck      (sck),
    .load_n   (load_n),
    .done     (done),
    .busy     (busy)
  );

  assign in_ready = !busy;
endmodule

// File: rtl/sdac_loader_checker.sv
module sdac_loader_checker #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sck,
  input logic sdo,
  input logic load_n,
  input logic busy,
  input logic done
);
  logic sck_prev;
  int   rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      rise_cnt <= 0;
    end else begin
      sck_prev <= sck;
      if (in_valid && in_ready) rise_cnt <= 0;
      else if (sck && !sck_prev) rise_cnt <= rise_cnt + 1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R7
  AST_SDO_CHANGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> !sck); // R3
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |=> load_n); // R4
  AST_LOAD_WITH_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> !sck); // R4
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |-> (rise_cnt == WORD_W)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(load_n)); // R5
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready); // R1
endmodule

bind serial_dac_loader sdac_loader_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sck      (sck),
  .sdo      (sdo),
  .load_n   (load_n),
  .busy     (busy),
  .done     (done)
);

// File: tb/serial_dac_loader_bench.sv
module serial_dac_loader_bench;
  localparam int W = 16;
  localparam int H = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, sck, sdo, load_n, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int transfers = 0;
  bit finished = 1'b0;
  logic [W-1:0] expq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_dac_loader #(.WORD_W(W), .HALF_CYC(H)) u_serial_dac_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sck(sck), .sdo(sdo), .load_n(load_n),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver: pushes the expected word when the handshake is seen
  task automatic send(input logic [W-1:0] w, input bit scramble);
    @(posedge clk); #1;
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) begin
      @(posedge clk); #1;
    end
    expq.push_back(w);
    @(posedge clk); #1;
    if (scramble) begin
      for (int i = 0; i < 20; i++) begin
        in_data  = in_data ^ 16'h5A3C;
        in_valid = 1'b1;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    logic         prev_sck = 1'b0;
    int           accept_cyc = 0;
    int           rise_k = 0;
    logic [W-1:0] acc = '0;
    logic [W-1:0] expw;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!busy && sck) check(1'b0, "R7 sck high while idle", 1, 0);
        if (sck && !prev_sck) begin
          check(cyc == accept_cyc + (2*rise_k + 1)*H, "R7 sck rise timing",
                cyc - accept_cyc, (2*rise_k + 1)*H);
          check(!in_ready, "R1 ready low during transfer", in_ready, 0);
          acc = {acc[W-2:0], sdo};
          rise_k++;
        end
        if (!load_n) begin
          check(cyc == accept_cyc + 32*H + 1, "R4 load_n low timing",
                cyc - accept_cyc, 32*H + 1);
          check(rise_k == W, "R2 shift pulse count", rise_k, W);
          if (expq.size() == 0) begin
            check(1'b0, "R6 unexpected transfer", int'(acc), -1);
          end else begin
            expw = expq.pop_front();
            check(acc == expw, "R3/R6 shifted word", int'(acc), int'(expw));
          end
          transfers++;
        end
        if (done) begin
          check(cyc == accept_cyc + 32*H + 2, "R5 done timing",
                cyc - accept_cyc, 32*H + 2);
          check(in_ready, "R1 ready back with done", in_ready, 1);
        end
        if (in_valid && in_ready) begin
          accept_cyc = cyc + 1;
          rise_k = 0;
          acc = '0;
        end
        prev_sck = sck;
      end
    end
  end

  // Watchdog
  initial begin
    #(4*100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sck == 1'b0,    "R8 reset sck",    sck, 0);
    check(load_n == 1'b1, "R8 reset load_n", load_n, 1);
    check(sdo == 1'b0,    "R8 reset sdo",    sdo, 0);
    check(busy == 1'b0,   "R8 reset busy",   busy, 0);
    check(done == 1'b0,   "R8 reset done",   done, 0);
    check(in_ready,       "R8 reset ready",  in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    send(16'hA5C3, 1'b0);
    repeat (40) @(posedge clk);
    send(16'h8001, 1'b0);
    repeat (40) @(posedge clk);
    send(16'h0000, 1'b0);
    repeat (40) @(posedge clk);
    send(16'hFFFF, 1'b0);
    repeat (40) @(posedge clk);
    send(16'h1234, 1'b1);   // R6: data scrambled, valid held while busy
    repeat (40) @(posedge clk);
    send(16'h7FFE, 1'b0);   // back-to-back pair
    send(16'hC00C, 1'b0);
    repeat (60) @(posedge clk);

    check(expq.size() == 0, "R6 scoreboard drained", expq.size(), 0);
    check(transfers == 7,   "R1/R6 transfer count", transfers, 7);
    @(negedge clk);
    check(!sck && load_n && !busy, "R7 idle after traffic", sck, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule